// File: doc/BRIEF.md
# PLL Calibration Control Register Sequencer

This block holds a byte-wide control register for an external PLL and a small
sequencer that decides when that PLL is powered, when it is told to calibrate,
and when its output may be used. After a hardware reset or a one-cycle software
reset pulse, the register reloads from a parallel preload bus that carries the
non-volatile defaults. The sequencer then waits for a configuration-done strobe.
After that it halts, powers down, or starts calibration, depending on the
register contents.

Calibration can be started in three ways:
- automatically after configuration when the autostart field is set;
- by a later write that sets autostart while halted;
- by a self-clearing calibration-enable bit that only reacts to a 0-to-1 write.

Setting power-down at any time disables the PLL and abandons calibration. Clearing power-down again restarts calibration with no further write. The output-enable flag is raised only once the PLL reports lock. The sequencer state can always be read on a status port.

Register fields:

| Bit(s) | Field | Access |
|---|---|---|
| 7 | reserved | reads 0 |
| 6 | power-down (pdn) | read/write |
| 5 | output-type select | read/write |
| 4:2 | reserved | read/write |
| 1 | calibration enable (cal_en) | self-clearing |
| 0 | autostart (auto) | read/write |

State codes on the status port: RESET=0, CONFIG=1, HALT=2, CALIBRATE=3, WAIT_LOCK=4, RUN=5, POWERDOWN=6.

Top module: `pllseq_ctrl`

## Requirements
- R1: While `rst_n` is low, `state_o` reads 0 (RESET) and `rd_data_o` equals `preload_i` with bits 7 and 1 forced to 0. The first clock edge after reset is released moves the state to 1 (CONFIG).
- R2: A write updates bits 6, 5, 4:2 and 0 from `wr_data_i` on the next edge. Bit 7 always reads 0.
- R3: In CONFIG, a `cfg_done_i` strobe selects the next state:
  - POWERDOWN (6) when pdn=1;
  - CALIBRATE (3) when pdn=0 and auto=1;
  - HALT (2) otherwise.
- R4: In HALT, a write that sets auto to 1 moves the state to CALIBRATE one edge after the register shows the new value.
- R5: In HALT, WAIT_LOCK or RUN, a write of 1 to bit 1 while it reads 0 sets cal_en, and the sequencer then enters CALIBRATE. Writing 0 to bit 1 never clears it. It clears on the edge where `cal_done_i` is seen in CALIBRATE.
- R6: Writing 1 to cal_en has no effect in any of these cases:
  - the state is RESET, CONFIG, CALIBRATE or POWERDOWN;
  - pdn reads 1;
  - the same write sets pdn;
  - cal_en already reads 1.

  A repeated write of 1 yields only one calibration.
- R7: CALIBRATE moves to WAIT_LOCK when `cal_done_i` is high. WAIT_LOCK moves to RUN when `lock_i` is high.
- R8: `out_en_o` is high only in RUN while `lock_i` is high and pdn=0. It falls in the same cycle that `lock_i` falls, and the state returns to WAIT_LOCK on the next edge.
- R9: `pll_en_o` is high exactly when pdn=0 and the state is HALT, CALIBRATE, WAIT_LOCK or RUN. `cal_start_o` is high exactly in CALIBRATE with pdn=0. Writing pdn=1 therefore drops all three outputs right after the write edge, and the state becomes POWERDOWN on the following edge.
- R10: In POWERDOWN, once pdn reads 0, the next edge enters CALIBRATE with no other write.
- R11: A `swrst_i` pulse reloads the register as in R1 and returns the state to RESET. The sequence then proceeds as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| swrst_i | input | 1 | Software reset pulse, one cycle |
| preload_i | input | 8 | Non-volatile default image applied at reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| cfg_done_i | input | 1 | Configuration phase finished |
| cal_done_i | input | 1 | PLL reports calibration finished |
| lock_i | input | 1 | PLL lock indication |
| pll_en_o | output | 1 | PLL enable |
| cal_start_o | output | 1 | Calibration request, held until done |
| out_en_o | output | 1 | Clock output enable |
| state_o | output | 3 | Sequencer state code |

## Verification
A wrong sequencer state is visible on `state_o` on the edge where it occurs. It also changes `pll_en_o` or `cal_start_o` in that same cycle, so a misstep into CALIBRATE or POWERDOWN is caught one cycle after the stimulus. A wrong cal_en value appears on `rd_data_o` bit 1 right after the write edge. If that value is wrong, the sequencer either enters CALIBRATE when it should not or stays idle, and this shows on `state_o` one edge later. A lock-gating error shows on `out_en_o` within the same cycle as the `lock_i` change.

// File: rtl/pllseq_pkg.sv
// Package: field positions, masks and state codes shared by the
// register, the sequencer and the checker.
package pllseq_pkg;

    localparam int REG_W     = 8;
    localparam int BIT_RSV7  = 7;
    localparam int BIT_PDN   = 6;
    localparam int BIT_OTYPE = 5;
    localparam int RSV_HI    = 4;
    localparam int RSV_LO    = 2;
    localparam int BIT_CAL   = 1;
    localparam int BIT_AUTO  = 0;
    localparam int ST_W      = 3;

    // Bits loaded from a write or from the preload (bits 7 and 1 excluded).
    localparam logic [REG_W-1:0] CAL_MASK   = REG_W'(1) << BIT_CAL;
    localparam logic [REG_W-1:0] RSV7_MASK  = REG_W'(1) << BIT_RSV7;
    localparam logic [REG_W-1:0] FIELD_MASK = ~(CAL_MASK | RSV7_MASK);

    typedef enum logic [ST_W-1:0] {
        ST_RESET     = 3'd0,
        ST_CONFIG    = 3'd1,
        ST_HALT      = 3'd2,
        ST_CAL       = 3'd3,
        ST_WAIT_LOCK = 3'd4,
        ST_RUN       = 3'd5,
        ST_PDOWN     = 3'd6
    } seq_state_e;

endpackage

// File: rtl/pllseq_regfile.sv
// Module: pllseq_regfile
// Holds the control byte. Plain fields load from a write, or from the
// preload on either reset. The calibration-enable bit is set only by a 0-to-1
// write in a state that allows it. It is cleared by calibration-done, by
// power-down or by reset.
// Assumes at most one write per cycle and that swrst_i is a single-cycle pulse.
module pllseq_regfile
    import pllseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swrst_i,
    input  logic [REG_W-1:0] preload_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  seq_state_e       state_i,
    input  logic             cal_done_i,
    output logic [REG_W-1:0] ctl_o
);

    logic [REG_W-1:0] ctl_q;
    logic [REG_W-1:0] ctl_d;
    logic             cal_settable;
    logic             cal_rise_req;

    // A calibration request is only accepted once configuration is over and no calibration is running.
    always_comb cal_settable = (state_i == ST_HALT) || (state_i == ST_WAIT_LOCK) || (state_i == ST_RUN);

    // A qualifying 0-to-1 request with no power-down present or being written.
    always_comb cal_rise_req = wr_en_i && wr_data_i[BIT_CAL] && !ctl_q[BIT_CAL]
                               && !wr_data_i[BIT_PDN] && !ctl_q[BIT_PDN] && cal_settable;

    // Next register value: write merge, self-clear, power-down override.
    always_comb begin
        ctl_d = ctl_q;
        if (wr_en_i) begin
            ctl_d = (wr_data_i & FIELD_MASK) | (ctl_q & CAL_MASK);
        end
        if (cal_rise_req) begin
            ctl_d[BIT_CAL] = 1'b1;
        end
        if ((state_i == ST_CAL) && cal_done_i) begin
            ctl_d[BIT_CAL] = 1'b0;
        end
        if (ctl_d[BIT_PDN]) begin
            ctl_d[BIT_CAL] = 1'b0;
        end
    end

    // Register storage with preload on hardware or software reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= preload_i & FIELD_MASK;
        end else if (swrst_i) begin
            ctl_q <= preload_i & FIELD_MASK;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/pllseq_seq.sv
// Module: pllseq_seq
// Sequencer that walks reset, configuration, calibration, lock and run, and
// decodes the PLL-facing outputs from the state and the power-down field.
// Assumes ctl_i is the registered control byte, lock_i is synchronous to clk,
// and cal_done_i is only meaningful while calibration is requested.
module pllseq_seq
    import pllseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swrst_i,
    input  logic             cfg_done_i,
    input  logic             cal_done_i,
    input  logic             lock_i,
    input  logic [REG_W-1:0] ctl_i,
    output seq_state_e       state_o,
    output logic             pll_en_o,
    output logic             cal_start_o,
    output logic             out_en_o
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       pdn;
    logic       auto_go;
    logic       cal_req;
    logic       pll_on_state;

    // Field taps from the control byte.
    always_comb begin
        pdn     = ctl_i[BIT_PDN];
        auto_go = ctl_i[BIT_AUTO];
        cal_req = ctl_i[BIT_CAL];
    end

    // Next-state selection; power-down always wins over any start request.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: state_d = ST_CONFIG;
            ST_CONFIG: begin
                if (cfg_done_i) begin
                    if (pdn)          state_d = ST_PDOWN;
                    else if (auto_go) state_d = ST_CAL;
                    else              state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (pdn)                     state_d = ST_PDOWN;
                else if (auto_go || cal_req) state_d = ST_CAL;
            end
            ST_CAL: begin
                if (pdn)             state_d = ST_PDOWN;
                else if (cal_done_i) state_d = ST_WAIT_LOCK;
            end
            ST_WAIT_LOCK: begin
                if (pdn)          state_d = ST_PDOWN;
                else if (cal_req) state_d = ST_CAL;
                else if (lock_i)  state_d = ST_RUN;
            end
            ST_RUN: begin
                if (pdn)          state_d = ST_PDOWN;
                else if (cal_req) state_d = ST_CAL;
                else if (!lock_i) state_d = ST_WAIT_LOCK;
            end
            ST_PDOWN: begin
                if (!pdn) state_d = ST_CAL;
            end
            default: state_d = ST_RESET;
        endcase
    end

    // State register; either reset returns to the reset state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else if (swrst_i) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // States in which the PLL is allowed to run.
    always_comb pll_on_state = (state_q == ST_HALT) || (state_q == ST_CAL)
                               || (state_q == ST_WAIT_LOCK) || (state_q == ST_RUN);

    // Output decode, gated by the live power-down field and lock.
    always_comb begin
        pll_en_o    = pll_on_state && !pdn;
        cal_start_o = (state_q == ST_CAL) && !pdn;
        out_en_o    = (state_q == ST_RUN) && lock_i && !pdn;
    end

    assign state_o = state_q;

endmodule

// File: rtl/pllseq_ctrl.sv
// Module: pllseq_ctrl (top)
// Control register plus sequencer for an external PLL. The register feeds the
// sequencer, and the sequencer state feeds back to gate calibration requests.
// Assumes all inputs are synchronous to clk.
module pllseq_ctrl
    import pllseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        swrst_i,
    input  logic [7:0]  preload_i,
    input  logic        wr_en_i,
    input  logic [7:0]  wr_data_i,
    output logic [7:0]  rd_data_o,
    input  logic        cfg_done_i,
    input  logic        cal_done_i,
    input  logic        lock_i,
    output logic        pll_en_o,
    output logic        cal_start_o,
    output logic        out_en_o,
    output logic [2:0]  state_o
);

    logic [REG_W-1:0] ctl;
    seq_state_e       state;

    // Control register instance.
    pllseq_regfile u_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .swrst_i    (swrst_i),
        .preload_i  (preload_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .state_i    (state),
        .cal_done_i (cal_done_i),
        .ctl_o      (ctl)
    );

    // Sequencer instance.
    pllseq_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .swrst_i     (swrst_i),
        .cfg_done_i  (cfg_done_i),
        .cal_done_i  (cal_done_i),
        .lock_i      (lock_i),
        .ctl_i       (ctl),
        .state_o     (state),
        .pll_en_o    (pll_en_o),
        .cal_start_o (cal_start_o),
        .out_en_o    (out_en_o)
    );

    assign rd_data_o = ctl;
    assign state_o   = state;

endmodule

// File: rtl/pllseq_chk.sv
// Module: pllseq_chk
// Port-level checker for pllseq_ctrl, attached by bind below.
module pllseq_chk
    import pllseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       swrst_i,
    input logic       cal_done_i,
    input logic       lock_i,
    input logic [7:0] rd_data_o,
    input logic       pll_en_o,
    input logic       cal_start_o,
    input logic       out_en_o,
    input logic [2:0] state_o
);

    AST_RESET_TO_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'(ST_RESET) && !swrst_i) |=> (state_o == 3'(ST_CONFIG))); // R1

    AST_OUTEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_o |-> (state_o == 3'(ST_RUN) && lock_i)); // R8

    AST_PDN_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[6] |-> (!pll_en_o && !cal_start_o && !out_en_o)); // R9

    AST_CALSTART_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start_o |-> (state_o == 3'(ST_CAL))); // R9

    AST_CAL_DONE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'(ST_CAL) && cal_done_i && !rd_data_o[6] && !swrst_i)
        |=> (state_o == 3'(ST_WAIT_LOCK) && !rd_data_o[1])); // R7

    AST_PDOWN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'(ST_PDOWN) && !rd_data_o[6] && !swrst_i) |=> (state_o == 3'(ST_CAL))); // R10

    AST_CAL_SET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data_o[1]) |-> ($past(state_o) == 3'(ST_HALT) || $past(state_o) == 3'(ST_WAIT_LOCK)
                                 || $past(state_o) == 3'(ST_RUN))); // R6

endmodule

bind pllseq_ctrl pllseq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .swrst_i     (swrst_i),
    .cal_done_i  (cal_done_i),
    .lock_i      (lock_i),
    .rd_data_o   (rd_data_o),
    .pll_en_o    (pll_en_o),
    .cal_start_o (cal_start_o),
    .out_en_o    (out_en_o),
    .state_o     (state_o)
);

// File: tb/tb_pllseq_ctrl.sv
// Bench for pllseq_ctrl: the driver pushes expected items into a queue,
// and the monitor pops each one and compares it with the ports.
`timescale 1ns/1ps
module tb_pllseq_ctrl;

    localparam int WD_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       swrst_i = 1'b0;
    logic [7:0] preload_i = 8'hFF;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       cfg_done_i = 1'b0;
    logic       cal_done_i = 1'b0;
    logic       lock_i = 1'b0;
    logic       pll_en_o;
    logic       cal_start_o;
    logic       out_en_o;
    logic [2:0] state_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        string      tag;
        logic [2:0] st;
        logic [7:0] rd;
        logic       pll;
        logic       cal;
        logic       oe;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #2 clk = ~clk;

    pllseq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .swrst_i(swrst_i), .preload_i(preload_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
        .cfg_done_i(cfg_done_i), .cal_done_i(cal_done_i), .lock_i(lock_i),
        .pll_en_o(pll_en_o), .cal_start_o(cal_start_o), .out_en_o(out_en_o),
        .state_o(state_o)
    );

    // Push an expectation. The three PLL-facing outputs follow the R8 and R9 formulas.
    task automatic expect_now(input string tag, input logic [2:0] st, input logic [7:0] rd);
        exp_item_t it;
        #1;
        it.tag = tag;
        it.st  = st;
        it.rd  = rd;
        it.pll = !rd[6] && (st == 3'd2 || st == 3'd3 || st == 3'd4 || st == 3'd5);
        it.cal = !rd[6] && (st == 3'd3);
        it.oe  = !rd[6] && (st == 3'd5) && lock_i;
        sb_q.push_back(it);
        #0;
    endtask

    task automatic nx();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en_i = 1'b1;
        wr_data_i = d;
        nx();
        wr_en_i = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Monitor: compare every queued item against the ports.
    initial begin
        forever begin
            exp_item_t it;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            total++;
            if (state_o !== it.st || rd_data_o !== it.rd || pll_en_o !== it.pll
                || cal_start_o !== it.cal || out_en_o !== it.oe) begin
                bad++;
                $display("FAIL %s: got st=%0d rd=%h pll=%b cal=%b oe=%b exp st=%0d rd=%h pll=%b cal=%b oe=%b",
                         it.tag, state_o, rd_data_o, pll_en_o, cal_start_o, out_en_o,
                         it.st, it.rd, it.pll, it.cal, it.oe);
            end
        end
    end

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        #(WD_CYCLES * 4);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running exp finished");
            summary();
            $finish;
        end
    end

    // Driver: the stimulus sequence.
    initial begin
        repeat (3) nx();
        expect_now("R1 reset image", 3'd0, 8'h7D);
        rst_n = 1'b1;
        nx();
        expect_now("R1 reset to config", 3'd1, 8'h7D);
        cfg_done_i = 1'b1;
        nx();
        cfg_done_i = 1'b0;
        expect_now("R3 config with pdn", 3'd6, 8'h7D);
        wr(8'h3D);
        expect_now("R2 write fields", 3'd6, 8'h3D);
        nx();
        expect_now("R10 powerup restarts cal", 3'd3, 8'h3D);
        cal_done_i = 1'b1;
        nx();
        cal_done_i = 1'b0;
        expect_now("R7 cal done to wait", 3'd4, 8'h3D);
        lock_i = 1'b1;
        nx();
        expect_now("R8 run with lock", 3'd5, 8'h3D);
        lock_i = 1'b0;
        expect_now("R8 lock loss drops oe", 3'd5, 8'h3D);
        nx();
        expect_now("R8 back to wait", 3'd4, 8'h3D);
        lock_i = 1'b1;
        nx();
        expect_now("R7 lock to run", 3'd5, 8'h3D);
        wr(8'h3F);
        expect_now("R5 cal bit set", 3'd5, 8'h3F);
        wr(8'h3F);
        expect_now("R5 calibrate entered", 3'd3, 8'h3F);
        wr(8'h3D);
        expect_now("R5 write 0 keeps cal", 3'd3, 8'h3F);
        cal_done_i = 1'b1;
        nx();
        cal_done_i = 1'b0;
        expect_now("R5 self clear", 3'd4, 8'h3D);
        nx();
        expect_now("R6 single calibration", 3'd5, 8'h3D);
        wr(8'h7D);
        expect_now("R9 pdn drops outputs", 3'd5, 8'h7D);
        nx();
        expect_now("R9 powerdown state", 3'd6, 8'h7D);
        wr(8'h7F);
        expect_now("R6 cal ignored in pdn", 3'd6, 8'h7D);
        preload_i = 8'h20;
        swrst_i = 1'b1;
        nx();
        swrst_i = 1'b0;
        expect_now("R11 soft reset reload", 3'd0, 8'h20);
        nx();
        expect_now("R11 config after swrst", 3'd1, 8'h20);
        wr(8'h22);
        expect_now("R6 cal ignored in config", 3'd1, 8'h20);
        cfg_done_i = 1'b1;
        nx();
        cfg_done_i = 1'b0;
        expect_now("R3 halt without autostart", 3'd2, 8'h20);
        wr(8'h21);
        expect_now("R4 autostart written", 3'd2, 8'h21);
        nx();
        expect_now("R4 halt to calibrate", 3'd3, 8'h21);
        preload_i = 8'h00;
        swrst_i = 1'b1;
        nx();
        swrst_i = 1'b0;
        expect_now("R11 reload zero", 3'd0, 8'h00);
        nx();
        cfg_done_i = 1'b1;
        nx();
        cfg_done_i = 1'b0;
        expect_now("R3 halt again", 3'd2, 8'h00);
        wr(8'h02);
        expect_now("R5 cal set in halt", 3'd2, 8'h02);
        nx();
        expect_now("R5 halt to calibrate", 3'd3, 8'h02);
        cal_done_i = 1'b1;
        nx();
        cal_done_i = 1'b0;
        expect_now("R5 cleared after done", 3'd4, 8'h00);
        preload_i = 8'h01;
        swrst_i = 1'b1;
        nx();
        swrst_i = 1'b0;
        expect_now("R11 reload autostart", 3'd0, 8'h01);
        nx();
        cfg_done_i = 1'b1;
        nx();
        cfg_done_i = 1'b0;
        expect_now("R11 autostart calibrates", 3'd3, 8'h01);
        nx();
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule